// File: doc/BRIEF.md
# Serial Register-Pointer Target Front End

This block is the two-wire serial target that sits in front of the register file of a 16-bit port expander. It watches the synchronized clock and data lines and finds START and STOP conditions. It works out its own 7-bit target address from three strap inputs, each of which is wired to one of four places. It acknowledges traffic that carries that address. The block turns each transfer into register-file operations. In a write, the first byte is taken as a register pointer, and every byte after it becomes a one-cycle write strobe. In a read, the target returns register contents starting at the pointer it has kept.

The pointer is persistent. A write that holds only a pointer byte sets the location for later reads, and a repeated START leaves the pointer untouched. After every byte the pointer steps forward. It wraps inside a fixed group of registers, and any location outside the groups keeps its value. The register file answers a read request in the same cycle that the request is made.

The controller is a single state machine with these states:
- IDLE: released, waits for START.
- ADDR: shifts in the address byte.
- ACK_A: acknowledges a matching address.
- CMD: shifts in the pointer byte.
- WDATA: shifts in a data byte.
- ACK_W: acknowledges a pointer or data byte.
- RDATA: shifts a byte out.
- RACK: samples the master's acknowledge.

Its transitions are:
- START moves any state to ADDR.
- STOP moves any state to IDLE.
- ADDR goes to ACK_A after eight bits if the address matches, and to IDLE if it does not.
- ACK_A goes to RDATA for a read and to CMD for a write.
- CMD and WDATA go to ACK_W after eight bits.
- ACK_W goes to WDATA.
- RDATA goes to RACK after eight bits.
- RACK goes to RDATA on an ACK and to IDLE on a NACK.

Top module: `i2cx_target`

## Requirements
- R1: Strap codes are 2'b00 ground, 2'b01 supply, 2'b10 tied to SCL and 2'b11 tied to SDA. When the high and middle straps are both tied to SCL or SDA and the low strap is on ground or supply, the address is 4'b1010 followed by three bits, from first to last: (high==SDA), (middle==SDA), (low==supply).
- R2: When all three straps are tied to SCL or SDA, the address is 4'b1011 followed by (high==SDA), (middle==SDA), (low==SDA).
- R3: When the high strap is tied to SCL or SDA and the middle strap is on ground or supply, the address is 3'b110 followed by four bits: (low tied to SCL or SDA), (high==SDA), (middle==supply), (low is supply or SDA).
- R4: When the high strap is on ground or supply, no address is acknowledged. Any address byte that does not match is not acknowledged (NACK). The bytes that follow it, up to the next START, produce no write strobe and no ACK.
- R5: The target pulls SDA low during the ninth clock after a matching address byte and after every written byte. The pull enable only asserts while the synchronized SCL is low.
- R6: In a write, the first byte after the address becomes the pointer. Each data byte gives exactly one cycle of wr_en_o, with wr_addr_o set to the current pointer and wr_data_o set to the byte.
- R7: After each data byte the pointer steps forward. It wraps inside 0x00–0x01, 0x02–0x03, 0x04–0x07 and 0x10–0x17. Every other pointer value keeps its value.
- R8: A write that carries only a pointer byte, followed by STOP, leaves that pointer stored for a later, separate read.
- R9: For each byte read, rd_req_o pulses for one cycle with rd_addr_o equal to the pointer, and rd_data_i is taken in that same cycle. The byte goes out MSB first, and the pointer then steps by the R7 rules.
- R10: After a write, the pointer keeps its stepped value, so a read with no new pointer byte starts at the location after the last one written.
- R11: A repeated START between the pointer write and the read keeps the pointer.
- R12: A master NACK on a read byte ends the transfer. SDA stays released during any clocks that follow, until the next START.
- R13: After reset the pointer is 0x00, SDA is released, and no strobe is active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Serial clock line level |
| sda_i | input | 1 | Serial data line level |
| strap_hi_i | input | 2 | High address strap connection code |
| strap_mid_i | input | 2 | Middle address strap connection code |
| strap_lo_i | input | 2 | Low address strap connection code |
| sda_pull_o | output | 1 | 1 pulls SDA low |
| wr_en_o | output | 1 | One-cycle register write strobe |
| wr_addr_o | output | 8 | Register write address |
| wr_data_o | output | 8 | Register write data |
| rd_req_o | output | 1 | One-cycle register read request |
| rd_addr_o | output | 8 | Register read address (the pointer) |
| rd_data_i | input | 8 | Register read data, valid while rd_req_o is high |

## Verification
On every cycle, the assertions check four things. The SDA pull only starts while SCL is low. Write and read strobes never overlap, and each write strobe lasts exactly one cycle. The pointer steps by the group-wrap rule after every strobe. They also check that a valid decoded address carries one of the two legal prefixes. Other behaviour can only be shown by the bench's transfers: the exact address produced by each strap combination, pointer persistence across STOP and repeated START, NACK of foreign addresses, and silence after a master NACK.

// File: rtl/i2cx_pkg.sv
package i2cx_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ADDR,
        ST_ACK_A,
        ST_CMD,
        ST_WDATA,
        ST_ACK_W,
        ST_RDATA,
        ST_RACK
    } tgt_state_e;

    localparam logic [1:0] TIE_GND = 2'b00;
    localparam logic [1:0] TIE_SUP = 2'b01;
    localparam logic [1:0] TIE_SCL = 2'b10;
    localparam logic [1:0] TIE_SDA = 2'b11;

endpackage

// File: rtl/i2cx_sync.sv
module i2cx_sync #(
    parameter int W      = 2,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d_i,
    output logic [W-1:0] q_o
);
    logic [W-1:0] stage_q [STAGES];

    for (genvar g = 0; g < STAGES; g++) begin : g_stage
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                stage_q[g] <= '1;
            end else if (g == 0) begin
                stage_q[g] <= d_i;
            end else begin
                stage_q[g] <= stage_q[(g == 0) ? 0 : g-1];
            end
        end
    end

    assign q_o = stage_q[STAGES-1];
endmodule

// File: rtl/i2cx_addr_map.sv
module i2cx_addr_map
    import i2cx_pkg::*;
(
    input  logic [1:0] tie_hi_i,
    input  logic [1:0] tie_mid_i,
    input  logic [1:0] tie_lo_i,
    output logic [6:0] dev_addr_o,
    output logic       valid_o
);
    logic hi_bus, mid_bus, lo_bus;

    assign hi_bus  = tie_hi_i[1];
    assign mid_bus = tie_mid_i[1];
    assign lo_bus  = tie_lo_i[1];

    always_comb begin
        dev_addr_o = '0;
        valid_o    = 1'b0;
        if (hi_bus && mid_bus) begin
            valid_o    = 1'b1;
            dev_addr_o = {3'b101, lo_bus, tie_hi_i == TIE_SDA, tie_mid_i == TIE_SDA,
                          lo_bus ? (tie_lo_i == TIE_SDA) : (tie_lo_i == TIE_SUP)};
        end else if (hi_bus) begin
            valid_o    = 1'b1;
            dev_addr_o = {3'b110, lo_bus, tie_hi_i == TIE_SDA, tie_mid_i == TIE_SUP,
                          (tie_lo_i == TIE_SUP) || (tie_lo_i == TIE_SDA)};
        end
    end
endmodule

// File: rtl/i2cx_ptr_step.sv
module i2cx_ptr_step #(
    parameter int PW = 8
) (
    input  logic [PW-1:0] ptr_i,
    output logic [PW-1:0] ptr_o
);
    localparam logic [PW-2:0] PAIR_IN  = (PW-1)'(0);
    localparam logic [PW-2:0] PAIR_OUT = (PW-1)'(1);
    localparam logic [PW-3:0] QUAD_SEL = (PW-2)'(1);
    localparam logic [PW-4:0] OCT_SEL  = (PW-3)'(2);

    always_comb begin
        if (ptr_i[PW-1:1] == PAIR_IN || ptr_i[PW-1:1] == PAIR_OUT) begin
            ptr_o = {ptr_i[PW-1:1], ~ptr_i[0]};
        end else if (ptr_i[PW-1:2] == QUAD_SEL) begin
            ptr_o = {ptr_i[PW-1:2], ptr_i[1:0] + 2'd1};
        end else if (ptr_i[PW-1:3] == OCT_SEL) begin
            ptr_o = {ptr_i[PW-1:3], ptr_i[2:0] + 3'd1};
        end else begin
            ptr_o = ptr_i;
        end
    end
endmodule

// File: rtl/i2cx_target.sv
module i2cx_target
    import i2cx_pkg::*;
#(
    parameter int DW          = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          scl_i,
    input  logic          sda_i,
    input  logic [1:0]    strap_hi_i,
    input  logic [1:0]    strap_mid_i,
    input  logic [1:0]    strap_lo_i,
    output logic          sda_pull_o,
    output logic          wr_en_o,
    output logic [DW-1:0] wr_addr_o,
    output logic [DW-1:0] wr_data_o,
    output logic          rd_req_o,
    output logic [DW-1:0] rd_addr_o,
    input  logic [DW-1:0] rd_data_i
);
    localparam int CW = $clog2(DW + 1);
    localparam logic [CW-1:0] BYTE_DONE = CW'(DW);
    localparam logic [CW-1:0] LAST_TX   = CW'(DW - 1);

    tgt_state_e    state, state_nxt;
    logic [1:0]    bus_s;
    logic          scl_s, sda_s, scl_q, sda_q;
    logic          scl_rise, scl_fall, start_det, stop_det;
    logic [6:0]    dev_addr;
    logic          addr_ok;
    logic [DW-1:0] shreg, ptr, ptr_nxt;
    logic [CW-1:0] bit_cnt;
    logic          mack;
    logic          rx_state, rx_done, load_rd;

    i2cx_sync #(.W(2), .STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .d_i({scl_i, sda_i}), .q_o(bus_s)
    );

    i2cx_addr_map u_map (
        .tie_hi_i(strap_hi_i), .tie_mid_i(strap_mid_i), .tie_lo_i(strap_lo_i),
        .dev_addr_o(dev_addr), .valid_o(addr_ok)
    );

    i2cx_ptr_step #(.PW(DW)) u_step (.ptr_i(ptr), .ptr_o(ptr_nxt));

    assign scl_s = bus_s[1];
    assign sda_s = bus_s[0];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            scl_q <= 1'b1;
            sda_q <= 1'b1;
        end else begin
            scl_q <= scl_s;
            sda_q <= sda_s;
        end
    end

    assign scl_rise  = scl_s & ~scl_q;
    assign scl_fall  = ~scl_s & scl_q;
    assign start_det = scl_s & scl_q & sda_q & ~sda_s;
    assign stop_det  = scl_s & scl_q & ~sda_q & sda_s;

    assign rx_state = (state == ST_ADDR) || (state == ST_CMD) || (state == ST_WDATA);
    assign rx_done  = rx_state && scl_fall && (bit_cnt == BYTE_DONE);
    assign load_rd  = scl_fall && (((state == ST_ACK_A) && shreg[0]) ||
                                   ((state == ST_RACK) && mack));

    // next-state logic
    always_comb begin
        state_nxt = state;
        unique case (state)
            ST_IDLE:  state_nxt = ST_IDLE;
            ST_ADDR:  if (rx_done)
                          state_nxt = (addr_ok && shreg[DW-1:1] == dev_addr) ? ST_ACK_A : ST_IDLE;
            ST_ACK_A: if (scl_fall) state_nxt = shreg[0] ? ST_RDATA : ST_CMD;
            ST_CMD:   if (rx_done) state_nxt = ST_ACK_W;
            ST_WDATA: if (rx_done) state_nxt = ST_ACK_W;
            ST_ACK_W: if (scl_fall) state_nxt = ST_WDATA;
            ST_RDATA: if (scl_fall && bit_cnt == LAST_TX) state_nxt = ST_RACK;
            ST_RACK:  if (scl_fall) state_nxt = mack ? ST_RDATA : ST_IDLE;
        endcase
        if (stop_det)  state_nxt = ST_IDLE;
        if (start_det) state_nxt = ST_ADDR;
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nxt;
    end

    // datapath: shifter, bit counter, pointer, write strobe
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            shreg     <= '0;
            bit_cnt   <= '0;
            ptr       <= '0;
            mack      <= 1'b0;
            wr_en_o   <= 1'b0;
            wr_addr_o <= '0;
            wr_data_o <= '0;
        end else begin
            wr_en_o <= 1'b0;
            if (start_det || stop_det) begin
                bit_cnt <= '0;
            end else begin
                if (rx_state && scl_rise && bit_cnt != BYTE_DONE) begin
                    shreg   <= {shreg[DW-2:0], sda_s};
                    bit_cnt <= bit_cnt + 1'b1;
                end
                if (rx_done) begin
                    bit_cnt <= '0;
                    if (state == ST_CMD) ptr <= shreg;
                    if (state == ST_WDATA) begin
                        wr_en_o   <= 1'b1;
                        wr_addr_o <= ptr;
                        wr_data_o <= shreg;
                        ptr       <= ptr_nxt;
                    end
                end
                if (state == ST_RDATA && scl_fall) begin
                    if (bit_cnt == LAST_TX) begin
                        bit_cnt <= '0;
                    end else begin
                        shreg   <= {shreg[DW-2:0], 1'b0};
                        bit_cnt <= bit_cnt + 1'b1;
                    end
                end
                if (state == ST_RACK && scl_rise) mack <= ~sda_s;
                if (load_rd) begin
                    shreg   <= rd_data_i;
                    ptr     <= ptr_nxt;
                    bit_cnt <= '0;
                end
            end
        end
    end

    // outputs
    always_comb begin
        sda_pull_o = (state == ST_ACK_A) || (state == ST_ACK_W) ||
                     ((state == ST_RDATA) && !shreg[DW-1]);
        rd_req_o   = load_rd;
        rd_addr_o  = ptr;
    end
endmodule

// File: rtl/i2cx_target_chk.sv
module i2cx_target_chk #(
    parameter int DW = 8
) (
    input logic          clk,
    input logic          rst_n,
    input logic          sda_pull,
    input logic          wr_en,
    input logic [DW-1:0] wr_addr,
    input logic          rd_req,
    input logic [DW-1:0] rd_addr,
    input logic          scl_s,
    input logic [DW-1:0] ptr,
    input logic [6:0]    dev_addr,
    input logic          addr_ok
);
    function automatic logic [DW-1:0] grp_next(input logic [DW-1:0] p);
        int v, r;
        v = int'(p);
        if (v < 2)                 r = (v + 1) % 2;
        else if (v < 4)            r = 2 + (v - 1) % 2;
        else if (v < 8)            r = 4 + (v - 3) % 4;
        else if (v >= 16 && v < 24) r = 16 + (v - 15) % 8;
        else                       r = v;
        return DW'(r);
    endfunction

    a_r5_pull_rise_scl_low: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sda_pull) |-> !scl_s);

    a_r6_wr_single: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> !wr_en);

    a_r7_wr_ptr_step: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> ptr == grp_next(wr_addr));

    a_r9_rd_ptr_step: assert property (@(posedge clk) disable iff (!rst_n)
        rd_req |=> ptr == grp_next($past(rd_addr)));

    a_r9_strobe_excl: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({wr_en, rd_req}));

    a_r1_addr_prefix: assert property (@(posedge clk) disable iff (!rst_n)
        addr_ok |-> (dev_addr[6:4] == 3'b101 || dev_addr[6:4] == 3'b110));
endmodule

bind i2cx_target i2cx_target_chk #(.DW(DW)) u_chk (
    .clk(clk), .rst_n(rst_n), .sda_pull(sda_pull_o), .wr_en(wr_en_o),
    .wr_addr(wr_addr_o), .rd_req(rd_req_o), .rd_addr(rd_addr_o),
    .scl_s(scl_s), .ptr(ptr), .dev_addr(dev_addr), .addr_ok(addr_ok)
);

// File: tb/i2cx_target_tb.sv
module i2cx_target_tb;
    localparam int Q = 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic scl_m = 1'b1, sda_m = 1'b1;
    logic [1:0] s_hi = 2'b11, s_mid = 2'b10, s_lo = 2'b00;
    logic sda_pull, wr_en, rd_req;
    logic [7:0] wr_addr, wr_data, rd_addr, rd_data;
    logic sda_line;

    int errors = 0, checks = 0, log_n = 0, pull_cnt = 0;
    logic done = 1'b0;
    logic [7:0] mem [256];
    logic [7:0] exp_mem [256];
    logic [7:0] log_a [256];
    logic [7:0] log_d [256];
    logic [7:0] mptr = 8'h00;

    always #10 clk = ~clk;

    assign sda_line = sda_m & ~sda_pull;
    assign rd_data  = mem[rd_addr];

    i2cx_target u_dut (
        .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_line),
        .strap_hi_i(s_hi), .strap_mid_i(s_mid), .strap_lo_i(s_lo),
        .sda_pull_o(sda_pull), .wr_en_o(wr_en), .wr_addr_o(wr_addr),
        .wr_data_o(wr_data), .rd_req_o(rd_req), .rd_addr_o(rd_addr),
        .rd_data_i(rd_data)
    );

    always @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < 256; i++) mem[i] = 8'(i * 37 + 5);
        end else if (wr_en) begin
            mem[wr_addr] = wr_data;
            log_a[log_n % 256] = wr_addr;
            log_d[log_n % 256] = wr_data;
            log_n = log_n + 1;
        end
        if (sda_pull) pull_cnt = pull_cnt + 1;
    end

    function automatic logic [7:0] nxt_ptr(input logic [7:0] p);
        int v;
        v = int'(p);
        if (v <= 1) return 8'(v ^ 1);
        if (v <= 3) return 8'(v ^ 1);
        if (v <= 7) return 8'(((v + 1) & 3) | 4);
        if (v >= 16 && v <= 23) return 8'(((v + 1) & 7) | 16);
        return p;
    endfunction

    // returns {valid, 7-bit address}
    function automatic logic [7:0] exp_addr(input logic [1:0] h, m, l);
        logic hb, mb, lb;
        hb = (h == 2'b10 || h == 2'b11);
        mb = (m == 2'b10 || m == 2'b11);
        lb = (l == 2'b10 || l == 2'b11);
        if (hb && mb && lb) return {1'b1, 4'b1011, h == 2'b11, m == 2'b11, l == 2'b11};
        if (hb && mb)       return {1'b1, 4'b1010, h == 2'b11, m == 2'b11, l == 2'b01};
        if (hb)             return {1'b1, 3'b110, lb, h == 2'b11, m == 2'b01, l == 2'b01 || l == 2'b11};
        return 8'h00;
    endfunction

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wq();
        repeat (Q) @(negedge clk);
    endtask

    task automatic i2c_start();
        sda_m = 1'b1; wq(); scl_m = 1'b1; wq(); sda_m = 1'b0; wq(); scl_m = 1'b0; wq();
    endtask

    task automatic i2c_stop();
        sda_m = 1'b0; wq(); scl_m = 1'b1; wq(); sda_m = 1'b1; wq(); wq();
    endtask

    task automatic send_byte(input logic [7:0] b, output logic ack);
        for (int i = 7; i >= 0; i--) begin
            sda_m = b[i]; wq(); scl_m = 1'b1; wq(); wq(); scl_m = 1'b0; wq();
        end
        sda_m = 1'b1; wq(); scl_m = 1'b1; wq();
        ack = !sda_line;
        wq(); scl_m = 1'b0; wq();
    endtask

    task automatic recv_byte(input logic give_ack, output logic [7:0] b);
        sda_m = 1'b1;
        for (int i = 0; i < 8; i++) begin
            wq(); scl_m = 1'b1; wq(); b = {b[6:0], sda_line}; wq(); scl_m = 1'b0; wq();
        end
        sda_m = !give_ack; wq(); scl_m = 1'b1; wq(); wq(); scl_m = 1'b0; wq();
        sda_m = 1'b1;
    endtask

    // write transfer: pointer byte then n data bytes, then STOP
    task automatic wr_txn(input logic [6:0] a, input logic [7:0] cmd, input int n);
        logic ack;
        logic [7:0] d;
        logic [7:0] ea [16];
        logic [7:0] ed [16];
        int base;
        base = log_n;
        i2c_start();
        send_byte({a, 1'b0}, ack); chk("R5 address ACK", int'(ack), 1);
        send_byte(cmd, ack);       chk("R5 pointer byte ACK", int'(ack), 1);
        mptr = cmd;
        for (int i = 0; i < n; i++) begin
            d = 8'($urandom);
            send_byte(d, ack); chk("R5 data byte ACK", int'(ack), 1);
            ea[i] = mptr; ed[i] = d;
            exp_mem[mptr] = d;
            mptr = nxt_ptr(mptr);
        end
        i2c_stop();
        chk("R6 write strobe count", log_n - base, n);
        for (int i = 0; i < n; i++) begin
            chk(i == 0 ? "R6 first write address" : "R7 stepped write address",
                int'(log_a[(base + i) % 256]), int'(ea[i]));
            chk("R6 write data", int'(log_d[(base + i) % 256]), int'(ed[i]));
        end
    endtask

    // read n bytes after START already issued; last byte NACKed
    task automatic rd_bytes(input logic [6:0] a, input int n, input string req);
        logic ack;
        logic [7:0] b;
        send_byte({a, 1'b1}, ack); chk("R5 read address ACK", int'(ack), 1);
        for (int i = 0; i < n; i++) begin
            recv_byte(i != n - 1, b);
            chk(req, int'(b), int'(exp_mem[mptr]));
            mptr = nxt_ptr(mptr);
        end
    endtask

    initial begin
        repeat (180000) @(posedge clk);
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        logic ack;
        logic [7:0] ea, wa, cmd;
        int base, pc, n;
        void'($urandom(32'h1c2d3e4f));
        for (int i = 0; i < 256; i++) exp_mem[i] = 8'(i * 37 + 5);
        repeat (5) @(negedge clk);
        chk("R13 SDA released in reset", int'(sda_pull), 0);
        rst_n = 1'b1;
        repeat (5) @(negedge clk);
        chk("R13 no write strobe after reset", int'(wr_en), 0);
        chk("R13 no read request after reset", int'(rd_req), 0);
        chk("R13 pointer at 0x00", int'(rd_addr), 0);

        // R13: read with no pointer byte starts at 0x00
        i2c_start(); rd_bytes(7'h54, 3, "R13 read from reset pointer"); i2c_stop();

        // strap decoding, R1 R2 R3 R4
        for (int it = 0; it < 24; it++) begin
            s_hi = 2'($urandom); s_mid = 2'($urandom); s_lo = 2'($urandom);
            if (it < 4) s_hi = 2'b10 + 2'(it % 2);
            ea = exp_addr(s_hi, s_mid, s_lo);
            wq();
            if (ea[7]) begin
                i2c_start(); send_byte({ea[6:0], 1'b0}, ack); i2c_stop();
                if (ea[6:4] == 3'b110)      chk("R3 decoded address ACK", int'(ack), 1);
                else if (ea[3])             chk("R2 decoded address ACK", int'(ack), 1);
                else                        chk("R1 decoded address ACK", int'(ack), 1);
                wa = {1'b0, ea[6:0] ^ 7'(1 << ($urandom % 7))};
                i2c_start(); send_byte({wa[6:0], 1'b0}, ack); i2c_stop();
                chk("R4 foreign address NACK", int'(ack), 0);
            end else begin
                i2c_start(); send_byte({7'($urandom), 1'b0}, ack); i2c_stop();
                chk("R4 unstrapped address NACK", int'(ack), 0);
            end
        end
        s_hi = 2'b11; s_mid = 2'b10; s_lo = 2'b00;
        wq();

        // R4: foreign address then data bytes produce nothing
        base = log_n; pc = pull_cnt;
        i2c_start(); send_byte({7'h55, 1'b0}, ack);
        send_byte(8'h10, ack); send_byte(8'hA5, ack); i2c_stop();
        chk("R4 no strobe after foreign address", log_n - base, 0);
        chk("R4 no ACK after foreign address", pull_cnt - pc, 0);

        // directed group wrap corners, R7
        wr_txn(7'h54, 8'h17, 3);
        wr_txn(7'h54, 8'h07, 3);
        wr_txn(7'h54, 8'h03, 2);
        wr_txn(7'h54, 8'h30, 2);

        // random writes each followed by a read with no new pointer, R10
        for (int it = 0; it < 6; it++) begin
            case ($urandom % 10)
                0: cmd = 8'h00; 1: cmd = 8'h01; 2: cmd = 8'h02; 3: cmd = 8'h05;
                4: cmd = 8'h06; 5: cmd = 8'h10; 6: cmd = 8'h14; 7: cmd = 8'h16;
                8: cmd = 8'h09; default: cmd = 8'h17;
            endcase
            n = 1 + int'($urandom % 9);
            wr_txn(7'h54, cmd, n);
            i2c_start(); rd_bytes(7'h54, 2, "R10 read continues after write"); i2c_stop();
        end

        // R8: pointer-only write, STOP, then separate read
        wr_txn(7'h54, 8'h12, 0);
        i2c_start(); rd_bytes(7'h54, 4, "R8 read from stored pointer"); i2c_stop();

        // R11 and R9: pointer write, repeated START, read across a wrap
        i2c_start();
        send_byte({7'h54, 1'b0}, ack);
        send_byte(8'h06, ack); mptr = 8'h06;
        i2c_start(); rd_bytes(7'h54, 5, "R11 read after repeated START"); i2c_stop();
        i2c_start();
        send_byte({7'h54, 1'b0}, ack);
        send_byte(8'h01, ack); mptr = 8'h01;
        i2c_start(); rd_bytes(7'h54, 3, "R9 read stepping in pair"); i2c_stop();

        // R12: master NACK then further clocks without START
        wr_txn(7'h54, 8'h11, 0);
        i2c_start(); rd_bytes(7'h54, 2, "R9 read before NACK");
        pc = pull_cnt; base = log_n;
        send_byte(8'hFF, ack);
        send_byte(8'h00, ack);
        chk("R12 no ACK after master NACK", int'(ack), 0);
        chk("R12 SDA released after master NACK", pull_cnt - pc, 0);
        chk("R12 no strobe after master NACK", log_n - base, 0);
        i2c_stop();
        i2c_start(); rd_bytes(7'h54, 1, "R12 pointer after NACKed read"); i2c_stop();

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule